// File: doc/BRIEF.md
# Serial Port in SPI Master Mode

This block is a byte-wide serial port that, once its two-bit operating-mode field selects master-SPI operation, drives a serial clock and a data-out line and samples a data-in line. Software loads bytes through a small register interface. Each written byte waits in a one-entry transmit buffer, then moves into a shift register and goes out as an 8-bit frame. The byte clocked in during the same frame goes into a one-entry receive buffer.

Clock polarity, clock phase and bit order are set in one control register. That same write may also select master-SPI mode. A divider register sets the serial clock rate. Two flags report the state of the transmit path: buffer empty and frame finished. Each flag drives an interrupt line, and the line is asserted only when both its own enable and a global enable input are set. The transmitter owns the serial clock, so the receiver only captures data while the transmitter is running frames. Turning the transmitter off takes effect once all queued data has left. Turning the receiver off discards whatever it holds.

Top module: `usart_spi_master`

## Requirements
- R1: After reset the mode register (address 3) reads 0x02, the status register (address 1) reads 0x20, the enable register (address 2) and the divider (address 4) read 0, and both interrupt outputs and both pin-ownership outputs are low.
- R2: The mode field is mode-register bits 7:6, encoded 00 asynchronous, 01 synchronous, 10 reserved, 11 master SPI. A byte waiting in the transmit buffer starts a frame only while the field is 11. Under any other value it stays queued and the serial clock does not toggle.
- R3: The mode register holds bit order at bit 2 (1 = least significant bit first), clock phase at bit 1 and clock polarity at bit 0. All three and the mode field are set by a single write. Bits 5:3 always read 0.
- R4: The serial clock rests at the polarity level between frames. Its period is 2*(divider+1) system clocks, and it makes 16 transitions per frame.
- R5: With phase 0, both sides sample on the leading clock edge and change data on the trailing edge, and the first bit is valid before the first edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: With bit order 0, bit 7 goes out first and the first bit received lands in bit 7. With bit order 1, bit 0 goes first in both directions.
- R7: The buffer-empty flag (status bit 5) is 1 at reset. It clears when a write to the data register (address 0) is accepted, and sets again in the cycle after the byte moves into the shift register. A data write is accepted only while the flag is 1 and transmit enable is set. Otherwise it is ignored.
- R8: The frame-finished flag (status bit 6) sets when a frame ends while the transmit buffer is empty. It clears when 1 is written to status bit 6 or when the acknowledge input is pulsed.
- R9: The frame-finished interrupt is high exactly when its enable (enable-register bit 6), the global enable input and the frame-finished flag are all 1.
- R10: The buffer-empty interrupt is high exactly when its enable (enable-register bit 5), the global enable input and the buffer-empty flag are all 1.
- R11: Clearing transmit enable (enable-register bit 3) leaves the transmitter running until the frame in the shift register and the byte in the transmit buffer have both been sent. Only then is it released.
- R12: When receive enable (enable-register bit 4) is set, each finished frame is stored in the receive buffer, which is read at the data address, and status bit 7 is set. A read strobe at the data address clears bit 7. Clearing receive enable empties the buffer, so bit 7 reads 0 and the data reads 0. Frames that finish while the receiver is off are not stored.
- R13: With receive enable set and transmit enable clear, data writes are ignored and no serial clock is produced.
- R14: The transmit pin-ownership output is high while the transmitter is active, including the deferred period of R11. The receive pin-ownership output follows receive enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; at the data address it consumes the received byte |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| gie | input | 1 | Global interrupt enable |
| txc_ack | input | 1 | Interrupt-taken pulse that clears the frame-finished flag |
| irq_txc | output | 1 | Frame-finished interrupt |
| irq_dre | output | 1 | Buffer-empty interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_own | output | 1 | Transmitter controls the clock and data-out pins |
| rx_own | output | 1 | Receiver controls the data-in pin |

## Verification
The bench acts as an SPI slave that follows the configured polarity, phase and order, and it walks through all eight frame formats with several divider values.

- A swapped sampling edge or a reversed bit order shows up as a corrupted byte in one direction or the other.
- A wrong divider shows up as a wrong measured clock period.
- A byte written while the mode field is not 11 must stay queued with no clock activity. A design that ignores the mode field would clock it out at once.
- Back-to-back writes exercise the narrow window in which the buffer-empty flag clears and then sets again. A write made while the buffer is full must vanish.
- Turning the transmitter off with two bytes in flight must still deliver both. An immediate disable would lose the queued byte and drop pin ownership early.
- Turning the receiver off must wipe a byte that has not been read.

// File: rtl/usart_spi_pkg.sv
package usart_spi_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 3'd0,
        A_STAT  = 3'd1,
        A_ENAB  = 3'd2,
        A_MODE  = 3'd3,
        A_DIV   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_ASYNC = 2'b00,
        M_SYNC  = 2'b01,
        M_RSVD  = 2'b10,
        M_SPI   = 2'b11
    } mode_e;

    typedef struct packed {
        logic order;   // 1: least significant bit first
        logic phase;   // 0: sample on leading edge
        logic pol;     // idle level of the serial clock
    } frame_cfg_t;

endpackage

// File: rtl/usart_spi_clkgen.sv
module usart_spi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             edge_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } clk_st_t;

    clk_st_t st_d, st_q;

    // a half period lasts div+1 clocks; the edge pulse ends it
    always_comb begin
        st_d   = st_q;
        edge_o = run && (st_q.cnt == div);
        if (!run || edge_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/usart_spi_shifter.sv
module usart_spi_shifter
    import usart_spi_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  frame_cfg_t         cfg,
    input  logic               edge_i,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic               sck,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int EDGES = 2 * FRAME_W;
    localparam int CNT_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               tog;
        frame_cfg_t         cfg;
        logic [CNT_W-1:0]   edge_cnt;
        logic [FRAME_W-1:0] tx_sr;
        logic [FRAME_W-1:0] rx_sr;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   lead, sample, shift, skip_shift;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        lead       = ~st_q.edge_cnt[0];
        sample     = lead ^ st_q.cfg.phase;
        // phase 0: no shift after the final edge; phase 1: no shift on the first edge
        skip_shift = st_q.cfg.phase ? (st_q.edge_cnt == '0) : (st_q.edge_cnt == LAST_EDGE);
        shift      = !sample && !skip_shift;
        if (start && !st_q.busy) begin
            st_d.busy     = 1'b1;
            st_d.cfg      = cfg;
            st_d.tx_sr    = tx_word;
            st_d.edge_cnt = '0;
            st_d.tog      = 1'b0;
        end else if (st_q.busy && edge_i) begin
            st_d.tog = ~st_q.tog;
            if (sample) begin
                if (st_q.cfg.order) st_d.rx_sr = {miso, st_q.rx_sr[FRAME_W-1:1]};
                else                st_d.rx_sr = {st_q.rx_sr[FRAME_W-2:0], miso};
            end
            if (shift) begin
                if (st_q.cfg.order) st_d.tx_sr = st_q.tx_sr >> 1;
                else                st_d.tx_sr = st_q.tx_sr << 1;
            end
            if (st_q.edge_cnt == LAST_EDGE) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.edge_cnt = '0;
            end else begin
                st_d.edge_cnt = st_q.edge_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign sck     = st_q.busy ? (st_q.cfg.pol ^ st_q.tog) : cfg.pol;
    assign mosi    = st_q.cfg.order ? st_q.tx_sr[0] : st_q.tx_sr[FRAME_W-1];
    assign rx_word = st_q.rx_sr;
endmodule

// File: rtl/usart_spi_regs.sv
module usart_spi_regs
    import usart_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              gie,
    input  logic              txc_ack,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx,
    output logic              start,
    output logic [DATA_W-1:0] tx_word,
    output frame_cfg_t        cfg,
    output logic [DIV_W-1:0]  div,
    output logic              irq_txc,
    output logic              irq_dre,
    output logic              tx_own,
    output logic              rx_own,
    output mode_e             mode,
    output logic              dre,
    output logic              rx_en,
    output logic              rx_full
);
    typedef struct packed {
        mode_e             mode;
        frame_cfg_t        cfg;
        logic              txc_ie;
        logic              dre_ie;
        logic              rx_en;
        logic              tx_en;
        logic              tx_act;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] tx_buf;
        logic              tx_full;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_full;
        logic              txc;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = st_q.tx_full && st_q.tx_act && (st_q.mode == M_SPI) && !eng_busy;
        if (start) st_d.tx_full = 1'b0;

        if (eng_done) begin
            if (st_q.rx_en) begin
                st_d.rx_buf  = eng_rx;
                st_d.rx_full = 1'b1;
            end
            if (!st_q.tx_full) st_d.txc = 1'b1;
        end
        if (rd_en && (rd_addr == A_DATA)) st_d.rx_full = 1'b0;
        if (txc_ack) st_d.txc = 1'b0;

        if (wr_en) begin
            case (wr_addr)
                A_DATA: if (st_q.tx_en && !st_q.tx_full) begin
                    st_d.tx_buf  = wr_data;
                    st_d.tx_full = 1'b1;
                end
                A_STAT: if (wr_data[6]) st_d.txc = 1'b0;
                A_ENAB: begin
                    st_d.txc_ie = wr_data[6];
                    st_d.dre_ie = wr_data[5];
                    st_d.rx_en  = wr_data[4];
                    st_d.tx_en  = wr_data[3];
                    if (!wr_data[4]) begin
                        st_d.rx_full = 1'b0;
                        st_d.rx_buf  = '0;
                    end
                end
                A_MODE: begin
                    st_d.mode = mode_e'(wr_data[7:6]);
                    st_d.cfg  = '{order: wr_data[2], phase: wr_data[1], pol: wr_data[0]};
                end
                A_DIV:  st_d.div = DIV_W'(wr_data);
                default: ;
            endcase
        end
        // transmitter stays active while anything is still queued or shifting
        st_d.tx_act = st_d.tx_en || (st_q.tx_act && (eng_busy || start || st_d.tx_full));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cfg.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_DATA:  rd_data = st_q.rx_buf;
            A_STAT:  rd_data = {st_q.rx_full, st_q.txc, ~st_q.tx_full, 5'b0};
            A_ENAB:  rd_data = {1'b0, st_q.txc_ie, st_q.dre_ie, st_q.rx_en, st_q.tx_en, 3'b0};
            A_MODE:  rd_data = {st_q.mode, 3'b0, st_q.cfg.order, st_q.cfg.phase, st_q.cfg.pol};
            A_DIV:   rd_data = DATA_W'(st_q.div);
            default: rd_data = '0;
        endcase
    end

    assign tx_word = st_q.tx_buf;
    assign cfg     = st_q.cfg;
    assign div     = st_q.div;
    assign dre     = ~st_q.tx_full;
    assign irq_txc = st_q.txc_ie & gie & st_q.txc;
    assign irq_dre = st_q.dre_ie & gie & ~st_q.tx_full;
    assign tx_own  = st_q.tx_act;
    assign rx_own  = st_q.rx_en;
    assign mode    = st_q.mode;
    assign rx_en   = st_q.rx_en;
    assign rx_full = st_q.rx_full;
endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
    import usart_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              gie,
    input  logic              txc_ack,
    output logic              irq_txc,
    output logic              irq_dre,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              tx_own,
    output logic              rx_own
);
    logic              eng_busy, eng_done, eng_start, half_edge;
    logic [DATA_W-1:0] eng_rx, tx_word;
    logic [DIV_W-1:0]  div;
    frame_cfg_t        cfg;
    mode_e             mode;
    logic              dre, rx_en, rx_full;

    usart_spi_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .gie(gie), .txc_ack(txc_ack),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
        .start(eng_start), .tx_word(tx_word), .cfg(cfg), .div(div),
        .irq_txc(irq_txc), .irq_dre(irq_dre),
        .tx_own(tx_own), .rx_own(rx_own),
        .mode(mode), .dre(dre), .rx_en(rx_en), .rx_full(rx_full)
    );

    usart_spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div), .edge_o(half_edge)
    );

    usart_spi_shifter #(.FRAME_W(DATA_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .tx_word(tx_word), .cfg(cfg),
        .edge_i(half_edge), .miso(miso),
        .busy(eng_busy), .done(eng_done), .sck(sck), .mosi(mosi), .rx_word(eng_rx)
    );
endmodule

// File: rtl/usart_spi_master_chk.sv
module usart_spi_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] mode,
    input logic       pol,
    input logic       sck,
    input logic       dre,
    input logic       tx_own,
    input logic       rx_en,
    input logic       rx_full
);
    // R4: clock rests at polarity level when no frame runs
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == pol));

    // R2: a frame may begin only under master-SPI mode
    p_start_needs_spi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(mode) == 2'b11));

    // R7: buffer is empty once its byte has moved into the shifter
    p_dre_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> dre);

    // R13: a frame starts only with an active transmitter
    p_no_clock_without_tx_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_own));

    // R11 / R14: transmitter ownership held through every running frame
    p_own_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tx_own);

    // R12: disabling the receiver leaves nothing in its buffer
    p_flush_on_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en) |-> !rx_full);
endmodule

bind usart_spi_master usart_spi_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .mode(mode), .pol(cfg.pol),
    .sck(sck), .dre(dre), .tx_own(tx_own), .rx_en(rx_en), .rx_full(rx_full)
);

// File: tb/usart_spi_master_test.sv
`timescale 1ns/1ps
module usart_spi_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, txc_ack = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       irq_txc, irq_dre, sck, mosi, miso, tx_own, rx_own;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    usart_spi_master uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .gie(gie), .txc_ack(txc_ack),
        .irq_txc(irq_txc), .irq_dre(irq_dre), .sck(sck), .mosi(mosi), .miso(miso),
        .tx_own(tx_own), .rx_own(rx_own)
    );

    // ---------------- slave model ----------------
    logic       s_hold = 1'b1, s_prev = 1'b0, miso_r = 1'b0;
    logic       b_ord = 1'b0, b_pha = 1'b1;
    logic [7:0] s_tx, s_rx = '0, s_last_rx = '0;
    int         s_cnt = 0, s_bit = 0, s_frames = 0, s_edges = 0, cyc = 0, t0 = 0, s_period = 0;
    assign miso = miso_r;

    function automatic logic [7:0] slave_byte(input int n);
        return 8'(n * 37 + 90);
    endfunction
    function automatic int bidx(input int i, input logic ord);
        return ord ? i : 7 - i;
    endfunction

    initial s_tx = slave_byte(0);

    always @(posedge clk) begin
        #1;
        cyc++;
        if (s_hold) begin
            s_prev = sck; s_cnt = 0; s_bit = 0;
        end else if (sck !== s_prev) begin
            logic lead;
            s_prev = sck; s_edges++;
            lead = (s_cnt % 2 == 0);
            if (lead && s_cnt == 0) t0 = cyc;
            if (lead && s_cnt == 2) s_period = cyc - t0;
            if (lead ^ b_pha) begin
                s_rx[bidx(s_bit, b_ord)] = mosi;
                if (b_pha) s_bit++;
            end else begin
                if (!b_pha) s_bit++;
                if (s_bit < 8) miso_r = s_tx[bidx(s_bit, b_ord)];
            end
            s_cnt++;
            if (s_cnt == 16) begin
                s_last_rx = s_rx; s_frames++;
                s_tx = slave_byte(s_frames); s_cnt = 0; s_bit = 0;
            end
        end
        if (!s_hold && s_cnt == 0 && !b_pha) miso_r = s_tx[bidx(0, b_ord)];
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1; rd_addr = 3'd0;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_fmt(input logic [1:0] m, input logic ord, input logic pha, input logic pol);
        s_hold = 1'b1;
        wr(3'd3, {m, 3'b0, ord, pha, pol});
        b_ord = ord; b_pha = pha;
        @(negedge clk); @(negedge clk);
        s_hold = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        while (s_frames < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_dre();
        logic [7:0] v;
        rd(3'd1, v);
        while (!v[5]) begin @(negedge clk); rd(3'd1, v); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        int base, e0;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd3, v); chk(v == 8'h02, "R1 mode reg", v, 8'h02);
        rd(3'd1, v); chk(v == 8'h20, "R1 status", v, 8'h20);
        rd(3'd2, v); chk(v == 8'h00, "R1 enable reg", v, 0);
        rd(3'd4, v); chk(v == 8'h00, "R1 divider", v, 0);
        chk({irq_txc, irq_dre, tx_own, rx_own} == 4'b0, "R1 outputs", {irq_txc, irq_dre, tx_own, rx_own}, 0);
        chk(sck == 1'b0, "R4 idle level after reset", sck, 0);

        // R3 layout, reserved bits zero, single write
        set_fmt(2'b11, 1'b1, 1'b1, 1'b1);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk(v == 8'hC7, "R3 reserved bits read zero", v, 8'hC7);
        chk(sck == 1'b1, "R4 idle at polarity 1", sck, 1);
        set_fmt(2'b00, 1'b0, 1'b0, 1'b0);

        // R2 mode gating
        wr(3'd4, 8'd1);
        wr(3'd2, 8'h18);
        chk(tx_own && rx_own, "R14 ownership on enable", {tx_own, rx_own}, 3);
        wr(3'd0, 8'h3C);
        e0 = s_edges; base = s_frames;
        for (int m = 0; m < 3; m++) begin
            set_fmt(2'(m), 1'b0, 1'b0, 1'b0);
            repeat (60) @(negedge clk);
            chk(s_edges == e0, "R2 no clock outside SPI mode", s_edges - e0, 0);
            rd(3'd1, v); chk(v[5] == 1'b0, "R2 byte stays queued", v[5], 0);
        end
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0);
        wait_frames(base + 1);
        chk(s_last_rx == 8'h3C, "R2 queued byte sent in SPI mode", s_last_rx, 8'h3C);
        rd(3'd0, v); chk(v == slave_byte(base), "R12 received byte stored", v, slave_byte(base));
        pop();
        wr(3'd1, 8'h40);

        // R4 R5 R6 R8 R12 random formats
        for (int it = 0; it < 24; it++) begin
            logic ord, pha, pol; logic [7:0] b; int dv;
            ord = 1'($urandom); pha = 1'($urandom); pol = 1'($urandom);
            dv = $urandom_range(0, 3); b = 8'($urandom);
            if (it < 8) begin ord = it[0]; pha = it[1]; pol = it[2]; end
            set_fmt(2'b11, ord, pha, pol);
            wr(3'd4, 8'(dv));
            base = s_frames;
            wr(3'd0, b);
            wait_frames(base + 1);
            chk(s_last_rx == b, "R5 R6 data out", s_last_rx, b);
            rd(3'd0, v); chk(v == slave_byte(base), "R5 R6 data in", v, slave_byte(base));
            chk(s_period == 2 * (dv + 1), "R4 clock period", s_period, 2 * (dv + 1));
            chk(sck == pol, "R4 idle level after frame", sck, pol);
            rd(3'd1, v); chk(v[7:6] == 2'b11, "R8 R12 flags after frame", v[7:6], 3);
            pop();
            wr(3'd1, 8'h40);
            rd(3'd1, v); chk(v[7:6] == 2'b00, "R8 R12 flags cleared", v[7:6], 0);
        end

        // R7 buffer-empty timing and ignored write
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0);
        wr(3'd4, 8'd3);
        base = s_frames;
        wr(3'd0, 8'hA1);
        rd(3'd1, v); chk(v[5] == 1'b0, "R7 flag clears on write", v[5], 0);
        @(negedge clk);
        rd(3'd1, v); chk(v[5] == 1'b1, "R7 flag sets on load", v[5], 1);
        wr(3'd0, 8'hB2);
        repeat (5) @(negedge clk);
        rd(3'd1, v); chk(v[5] == 1'b0, "R7 flag low while queued", v[5], 0);
        wr(3'd0, 8'hC3);
        wait_frames(base + 2);
        repeat (200) @(negedge clk);
        chk(s_frames == base + 2, "R7 write while full ignored", s_frames - base, 2);
        chk(s_last_rx == 8'hB2, "R7 second byte sent", s_last_rx, 8'hB2);
        pop();

        // R8 R9 frame-finished interrupt
        wr(3'd2, 8'h58);
        gie = 1'b0; #0.5;
        chk(irq_txc == 1'b0, "R9 gated by global enable", irq_txc, 0);
        gie = 1'b1; #0.5;
        chk(irq_txc == 1'b1, "R9 asserted", irq_txc, 1);
        @(negedge clk); txc_ack = 1'b1; @(negedge clk); txc_ack = 1'b0;
        rd(3'd1, v); chk(v[6] == 1'b0, "R8 cleared by acknowledge", v[6], 0);
        chk(irq_txc == 1'b0, "R9 low without flag", irq_txc, 0);

        // R10 buffer-empty interrupt
        wr(3'd2, 8'h38);
        chk(irq_dre == 1'b1, "R10 asserted", irq_dre, 1);
        gie = 1'b0; #0.5;
        chk(irq_dre == 1'b0, "R10 gated by global enable", irq_dre, 0);
        gie = 1'b1;
        set_fmt(2'b01, 1'b0, 1'b0, 1'b0);
        wr(3'd0, 8'h11);
        chk(irq_dre == 1'b0, "R10 low while full", irq_dre, 0);
        base = s_frames;
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0);
        wait_frames(base + 1);
        pop();

        // R11 deferred transmitter disable
        wr(3'd2, 8'h18);
        base = s_frames;
        wr(3'd0, 8'h5E);
        wait_dre();
        wr(3'd0, 8'h6F);
        wr(3'd2, 8'h10);
        chk(tx_own == 1'b1, "R11 still owned after disable", tx_own, 1);
        wait_frames(base + 2);
        chk(s_last_rx == 8'h6F, "R11 queued byte completed", s_last_rx, 8'h6F);
        chk(tx_own == 1'b0, "R14 released after drain", tx_own, 0);
        pop();

        // R13 receiver alone does nothing
        e0 = s_edges;
        wr(3'd0, 8'h77);
        repeat (100) @(negedge clk);
        rd(3'd1, v); chk(v[5] == 1'b1, "R13 write ignored", v[5], 1);
        chk(s_edges == e0, "R13 no clock", s_edges - e0, 0);
        chk(rx_own == 1'b1 && tx_own == 1'b0, "R14 receive-only ownership", {tx_own, rx_own}, 1);

        // R12 flush on receiver disable
        wr(3'd2, 8'h18);
        base = s_frames;
        wr(3'd0, 8'h99);
        wait_frames(base + 1);
        rd(3'd1, v); chk(v[7] == 1'b1, "R12 buffer full", v[7], 1);
        wr(3'd2, 8'h08);
        rd(3'd1, v); chk(v[7] == 1'b0, "R12 flag flushed", v[7], 0);
        rd(3'd0, v); chk(v == 8'h00, "R12 data flushed", v, 0);
        chk(rx_own == 1'b0, "R14 receive released", rx_own, 0);
        base = s_frames;
        wr(3'd0, 8'h24);
        wait_frames(base + 1);
        rd(3'd1, v); chk(v[7] == 1'b0, "R12 not stored while off", v[7], 0);

        finish_run();
    end
endmodule